// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This combinational unit sits between a 32-bit core and a word-wide data memory that has per-byte write enables. For a store it takes the access code, the low address bits and the register value. It produces the byte-enable mask and a write word in which the stored bytes already sit in every lane they might occupy. For a load it takes the raw memory word and returns the register value. That value is the addressed byte, halfword or whole word, moved down to bit 0 and then sign- or zero-extended.

The access code is the 3-bit function field of a load or store: 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte, 101 unsigned halfword. Lanes are little-endian: lane 0 holds bits 7:0. The unit raises a flag for an access that does not fall on its natural boundary, but it still completes the access and never traps. Address arithmetic and the memory itself are handled elsewhere.

Top module: `lane_align_unit`

## Requirements
- R1: Code 000 (signed byte) returns the byte in lane `lane_ofs_i`, with its bit 7 copied into bits 31:8.
- R2: Code 100 (unsigned byte) returns the byte in lane `lane_ofs_i`, with bits 31:8 cleared.
- R3: Codes 001 and 101 return the halfword chosen by `lane_ofs_i[1]` (0 = bits 15:0, 1 = bits 31:16). Code 001 copies its bit 15 into bits 31:16, and code 101 clears bits 31:16.
- R4: Code 010 returns the memory word unchanged.
- R5: For byte codes (000, 100), `byte_en_o` is 4'b0001 shifted left by `lane_ofs_i`.
- R6: For halfword codes (001, 101), `byte_en_o` is 4'b0011 when `lane_ofs_i[1]` is 0 and 4'b1100 when it is 1; `lane_ofs_i[0]` has no effect.
- R7: For code 010, `byte_en_o` is 4'b1111 at every offset.
- R8: `mem_wdata_o` holds bits 7:0 of the store data in all four lanes for byte codes, bits 15:0 in both halves for halfword codes, and the store data unchanged for code 010. Store data bits above the access size do not reach the output.
- R9: `misalign_o` is 1 for a halfword code with `lane_ofs_i[0]`=1, and for code 010 with `lane_ofs_i` not 0. It is 0 for byte codes. A flagged access still produces its normal mask, write data and load value.
- R10: Codes 011, 110 and 111 produce `byte_en_o`=0, `mem_wdata_o`=0, `load_value_o`=0 and `misalign_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_op_i | input | 3 | Access code (size and signedness) |
| lane_ofs_i | input | 2 | Low address bits selecting the byte lane |
| store_data_i | input | 32 | Register value to be stored |
| mem_rdata_i | input | 32 | Raw word read from memory |
| byte_en_o | output | 4 | Per-lane write enable |
| mem_wdata_o | output | 32 | Write word with the store data replicated across lanes |
| load_value_o | output | 32 | Aligned and extended load result |
| misalign_o | output | 1 | Access is not on its natural boundary |

## Verification
The hardest behaviour to reach is the sign decision at the exact boundary. The aligner must tell an extracted 0x80 from 0x7F, and 0x8000 from 0x7FFF, while reading from the upper lanes rather than lane 0. A single memory word that holds 0x7FFF in its high half and 0x8000 in its low half reaches all of these cases: offsets 0, 1, 2 and 3 then give both polarities for both sizes. Misaligned halfword and word accesses are also driven, to show that the flag never changes the mask, the write data or the extracted value.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  localparam logic [2:0] OP_LB  = 3'b000;
  localparam logic [2:0] OP_LH  = 3'b001;
  localparam logic [2:0] OP_LW  = 3'b010;
  localparam logic [2:0] OP_LBU = 3'b100;
  localparam logic [2:0] OP_LHU = 3'b101;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  // Size class of an access code; unlisted codes map to SZ_NONE.
  function automatic acc_size_e size_of(input logic [2:0] op);
    case (op)
      OP_LB, OP_LBU: size_of = SZ_BYTE;
      OP_LH, OP_LHU: size_of = SZ_HALF;
      OP_LW:         size_of = SZ_WORD;
      default:       size_of = SZ_NONE;
    endcase
  endfunction

  // Unsigned extension is chosen by the top code bit.
  function automatic logic zero_ext_of(input logic [2:0] op);
    zero_ext_of = op[2];
  endfunction

  // Number of lanes a given size touches.
  function automatic int unsigned lanes_of(input acc_size_e sz, input int unsigned all_lanes);
    case (sz)
      SZ_BYTE: lanes_of = 1;
      SZ_HALF: lanes_of = 2;
      SZ_WORD: lanes_of = all_lanes;
      default: lanes_of = 0;
    endcase
  endfunction

endpackage

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e           size_i,
  input  logic [OFS_W-1:0]    ofs_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [LANES-1:0]    en_o,
  output logic [DATA_W-1:0]   wdata_o
);

  localparam int HALF_W = OFS_W - 1;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [OFS_W-1:0]  LANE_ID = OFS_W'(j);
    localparam logic [HALF_W-1:0] PAIR_ID = HALF_W'(j / 2);
    localparam int                IN_PAIR = j % 2;

    always_comb begin
      case (size_i)
        SZ_BYTE: begin
          en_o[j]           = (ofs_i == LANE_ID);
          wdata_o[8*j +: 8] = data_i[7:0];
        end
        SZ_HALF: begin
          en_o[j]           = (ofs_i[OFS_W-1:1] == PAIR_ID);
          wdata_o[8*j +: 8] = data_i[8*IN_PAIR +: 8];
        end
        SZ_WORD: begin
          en_o[j]           = 1'b1;
          wdata_o[8*j +: 8] = data_i[8*j +: 8];
        end
        default: begin
          en_o[j]           = 1'b0;
          wdata_o[8*j +: 8] = 8'h00;
        end
      endcase
    end
  end

  // The number of enabled lanes follows from the size alone.
  always_comb begin
    p_lane_count_r7: assert ($countones(en_o) == lanes_of(size_i, LANES));
  end

  // A byte store enables exactly one lane.
  always_comb begin
    if (size_i == SZ_BYTE)
      p_byte_single_lane_r5: assert ($onehot0(en_o) && en_o != '0);
  end

  // Every enabled lane of a byte store carries the low data byte.
  always_comb begin
    for (int k = 0; k < LANES; k++)
      if (size_i == SZ_BYTE && en_o[k])
        p_byte_lane_data_r8: assert (wdata_o[8*k +: 8] == data_i[7:0]);
  end

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int HALVES = LANES / 2,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e           size_i,
  input  logic                zext_i,
  input  logic [OFS_W-1:0]    ofs_i,
  input  logic [DATA_W-1:0]   word_i,
  output logic [DATA_W-1:0]   value_o
);

  localparam int HALF_W = OFS_W - 1;

  logic [7:0]  sel_byte;
  logic [15:0] sel_half;
  logic        byte_fill;
  logic        half_fill;

  always_comb begin
    sel_byte = '0;
    for (int j = 0; j < LANES; j++)
      if (ofs_i == OFS_W'(j)) sel_byte = word_i[8*j +: 8];
  end

  always_comb begin
    sel_half = '0;
    for (int k = 0; k < HALVES; k++)
      if (ofs_i[OFS_W-1:1] == HALF_W'(k)) sel_half = word_i[16*k +: 16];
  end

  assign byte_fill = ~zext_i & sel_byte[7];
  assign half_fill = ~zext_i & sel_half[15];

  always_comb begin
    case (size_i)
      SZ_BYTE: value_o = {{(DATA_W-8){byte_fill}}, sel_byte};
      SZ_HALF: value_o = {{(DATA_W-16){half_fill}}, sel_half};
      SZ_WORD: value_o = word_i;
      default: value_o = '0;
    endcase
  end

  always_comb begin
    if (size_i == SZ_BYTE && !zext_i)
      p_byte_sign_fill_r1: assert (value_o[DATA_W-1:8] == {(DATA_W-8){value_o[7]}});
  end

  always_comb begin
    if (size_i == SZ_BYTE && zext_i)
      p_byte_zero_fill_r2: assert (value_o[DATA_W-1:8] == '0);
  end

  always_comb begin
    if (size_i == SZ_HALF && zext_i)
      p_half_zero_fill_r3: assert (value_o[DATA_W-1:16] == '0);
  end

  always_comb begin
    if (size_i == SZ_WORD)
      p_word_passthrough_r4: assert (value_o == word_i);
  end

endmodule

// File: rtl/lane_misalign_check.sv
module lane_misalign_check
  import lane_align_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             misalign_o
);

  always_comb begin
    case (size_i)
      SZ_HALF: misalign_o = ofs_i[0];
      SZ_WORD: misalign_o = |ofs_i;
      default: misalign_o = 1'b0;
    endcase
  end

  always_comb begin
    if (size_i == SZ_BYTE || size_i == SZ_NONE)
      p_byte_never_flagged_r9: assert (!misalign_o);
  end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [2:0]        mem_op_i,
  input  logic [OFS_W-1:0]  lane_ofs_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [LANES-1:0]  byte_en_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] load_value_o,
  output logic              misalign_o
);

  acc_size_e acc_size;
  logic      zero_ext;

  assign acc_size = size_of(mem_op_i);
  assign zero_ext = zero_ext_of(mem_op_i);

  lane_store_pack #(.DATA_W(DATA_W)) u_store (
    .size_i  (acc_size),
    .ofs_i   (lane_ofs_i),
    .data_i  (store_data_i),
    .en_o    (byte_en_o),
    .wdata_o (mem_wdata_o)
  );

  lane_load_extract #(.DATA_W(DATA_W)) u_load (
    .size_i  (acc_size),
    .zext_i  (zero_ext),
    .ofs_i   (lane_ofs_i),
    .word_i  (mem_rdata_i),
    .value_o (load_value_o)
  );

  lane_misalign_check #(.OFS_W(OFS_W)) u_align (
    .size_i     (acc_size),
    .ofs_i      (lane_ofs_i),
    .misalign_o (misalign_o)
  );

  // Undefined codes leave every output quiet.
  always_comb begin
    if (acc_size == SZ_NONE)
      p_bad_code_quiet_r10: assert (byte_en_o == '0 && mem_wdata_o == '0 &&
                                    load_value_o == '0 && !misalign_o);
  end

  // A word access always enables every lane, aligned or not.
  always_comb begin
    if (mem_op_i == OP_LW)
      p_word_all_lanes_r7: assert (&byte_en_o);
  end

  // Halfword enables are one of the two aligned pairs.
  always_comb begin
    if (acc_size == SZ_HALF)
      p_half_pair_r6: assert (byte_en_o == LANES'(2'b11) ||
                              byte_en_o == (LANES'(2'b11) << (LANES - 2)));
  end

endmodule

// File: tb/lane_align_unit_test.sv
module lane_align_unit_test;

  logic        clk = 1'b0;
  logic [2:0]  op;
  logic [1:0]  ofs;
  logic [31:0] sdata;
  logic [31:0] rdata;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [31:0] lval;
  logic        mis;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lane_align_unit uut (
    .mem_op_i     (op),
    .lane_ofs_i   (ofs),
    .store_data_i (sdata),
    .mem_rdata_i  (rdata),
    .byte_en_o    (be),
    .mem_wdata_o  (wdata),
    .load_value_o (lval),
    .misalign_o   (mis)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ofs;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] lv;
    logic        mis;
  } vec_t;

  // Memory word 32'hF1827E93 (lanes 3..0 = F1 82 7E 93), store data 32'hA5C35E17.
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 2'd0, 4'b0001, 32'h17171717, 32'hFFFFFF93, 1'b0}, // R1 R5 R8
    '{3'b000, 2'd1, 4'b0010, 32'h17171717, 32'h0000007E, 1'b0}, // R1 R5
    '{3'b000, 2'd2, 4'b0100, 32'h17171717, 32'hFFFFFF82, 1'b0}, // R1 R5
    '{3'b000, 2'd3, 4'b1000, 32'h17171717, 32'hFFFFFFF1, 1'b0}, // R1 R5 R9
    '{3'b100, 2'd0, 4'b0001, 32'h17171717, 32'h00000093, 1'b0}, // R2 R5
    '{3'b100, 2'd2, 4'b0100, 32'h17171717, 32'h00000082, 1'b0}, // R2
    '{3'b001, 2'd0, 4'b0011, 32'h5E175E17, 32'h00007E93, 1'b0}, // R3 R6 R8
    '{3'b001, 2'd2, 4'b1100, 32'h5E175E17, 32'hFFFFF182, 1'b0}, // R3 R6
    '{3'b001, 2'd1, 4'b0011, 32'h5E175E17, 32'h00007E93, 1'b1}, // R6 R9
    '{3'b101, 2'd2, 4'b1100, 32'h5E175E17, 32'h0000F182, 1'b0}, // R3
    '{3'b101, 2'd3, 4'b1100, 32'h5E175E17, 32'h0000F182, 1'b1}, // R3 R9
    '{3'b010, 2'd0, 4'b1111, 32'hA5C35E17, 32'hF1827E93, 1'b0}, // R4 R7 R8
    '{3'b010, 2'd2, 4'b1111, 32'hA5C35E17, 32'hF1827E93, 1'b1}, // R7 R9
    '{3'b010, 2'd1, 4'b1111, 32'hA5C35E17, 32'hF1827E93, 1'b1}, // R9
    '{3'b011, 2'd0, 4'b0000, 32'h00000000, 32'h00000000, 1'b0}, // R10
    '{3'b110, 2'd1, 4'b0000, 32'h00000000, 32'h00000000, 1'b0}, // R10
    '{3'b111, 2'd3, 4'b0000, 32'h00000000, 32'h00000000, 1'b0}  // R10
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] a,
                       input logic [31:0] s, input logic [31:0] r);
    @(posedge clk);
    op = o; ofs = a; sdata = s; rdata = r;
    @(negedge clk);
  endtask

  initial begin
    op = 3'b011; ofs = 2'd0; sdata = '0; rdata = '0;
    @(negedge clk);
    // R10: idle undefined code before any access
    check32("R10 idle byte_en", {28'd0, be}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].ofs, 32'hA5C35E17, 32'hF1827E93);
      check32($sformatf("vec%0d byte_en", i), {28'd0, be}, {28'd0, VECS[i].be});
      check32($sformatf("vec%0d wdata", i), wdata, VECS[i].wd);
      check32($sformatf("vec%0d load", i), lval, VECS[i].lv);
      check32($sformatf("vec%0d misalign", i), {31'd0, mis}, {31'd0, VECS[i].mis});
    end

    // Sign boundaries: memory 32'h7FFF8000 (lanes 3..0 = 7F FF 80 00).
    apply(3'b000, 2'd1, '0, 32'h7FFF8000);
    check32("R1 byte 0x80", lval, 32'hFFFFFF80);
    apply(3'b000, 2'd3, '0, 32'h7FFF8000);
    check32("R1 byte 0x7F", lval, 32'h0000007F);
    apply(3'b100, 2'd2, '0, 32'h7FFF8000);
    check32("R2 byte 0xFF unsigned", lval, 32'h000000FF);
    apply(3'b001, 2'd0, '0, 32'h7FFF8000);
    check32("R3 half 0x8000 signed", lval, 32'hFFFF8000);
    apply(3'b001, 2'd2, '0, 32'h7FFF8000);
    check32("R3 half 0x7FFF signed", lval, 32'h00007FFF);
    apply(3'b101, 2'd0, '0, 32'h7FFF8000);
    check32("R3 half 0x8000 unsigned", lval, 32'h00008000);

    // R8: upper store bits must not leak into replicated lanes.
    apply(3'b000, 2'd2, 32'hFFFFFF00, '0);
    check32("R8 byte upper bits dropped", wdata, 32'h00000000);
    apply(3'b001, 2'd3, 32'h1234ABCD, '0);
    check32("R8 half replication", wdata, 32'hABCDABCD);
    check32("R6 ofs bit0 ignored", {28'd0, be}, 32'h0000000C);
    // R10: undefined code with busy data still quiet
    apply(3'b110, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check32("R10 busy wdata", wdata, 32'd0);
    check32("R10 busy load", lval, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule